// File: doc/BRIEF.md
# Configuration word sequencer

This block brings an external RF synthesizer/transmitter up after power-on without any processor work. When `start_i` is pulsed it presents a fixed power-up list of 21 register words, one at a time, to a downstream serial writer. Each 32-bit word is held on `word_o` with `word_valid_o` high until the writer returns `wr_done_i`. Some words start a timed operation inside the device: a supply/LO power-up, a VCO frequency calibration or a transmitter amplitude calibration. After each of those words the block waits for a fixed settling time before it offers the next word. The waits are counted in clock cycles from the parameter `CYC_PER_US`.

Once the power-up list has completed, `init_done_o` is set. From then on a request on `recal_req_i` runs a four-word recalibration list through the same engine. The system is expected to raise this request after every 10 °C of temperature drift. A request that arrives while a list is running is held and served once that list ends. The serial shifting itself and any sensing of the device are outside this block.

Top module: `cfg_seq_top`

## Requirements
- R1: While `rst_ni` is low, and until the first start, `busy_o`, `word_valid_o` and `init_done_o` are 0 and `word_o` is 0.
- R2: A one-cycle `start_i` while idle raises `busy_o` in the next cycle. The block then emits, in this order: 0x02000007, 0x0000002B, 0x0000000B, 0x1D32A64A, 0x2A20B929, 0x40003E88, 0x809FE520, 0x011F4827, 0x00000006, 0x01E28005, 0x00200004, 0x01890803, 0x00020642, 0xFFF7FFE1, 0x809FE720, 0x809FE560, 0x809FED60, 0x809FE5A0, 0x809FF5A0, 0x2800B929, 0x809F25A0.
- R3: A word stays unchanged on `word_o` with `word_valid_o` high until a rising edge where `wr_done_i` is high. Each such edge consumes exactly one word, whatever the writer's latency.
- R4: After the handshake of a word with no wait, the next word is valid in the very next cycle.
- R5: After the handshake of a timed word, `word_valid_o` stays low for exactly `CYC_PER_US` times the wait in µs, while `busy_o` stays high. The waits are 10 µs after power-up word 7, 800 µs after word 15, and 400 µs after words 17 and 19.
- R6: On the handshake of the 21st power-up word, `busy_o` falls and `init_done_o` rises in the same cycle.
- R7: The recalibration list is 0x809FE520, 0x2A20B929, 0xFFF7FFE1, 0x809FE720. An 800 µs wait follows the last word, with `busy_o` high. The list runs only while `init_done_o` is 1, and `init_done_o` stays 1 during it.
- R8: A recalibration request while idle with `init_done_o` at 0 is dropped: `busy_o` stays 0 and no word is emitted.
- R9: A recalibration request seen while busy is remembered. The recalibration list starts after one idle cycle once the running list ends, provided `init_done_o` is 1 by then.
- R10: `start_i` while busy has no effect on the running list. `start_i` while idle with `init_done_o` at 1 clears `init_done_o` in the next cycle and runs the power-up list again.
- R11: The low five bits of every emitted word hold its target register address, which is never above 11.
- R12: Asserting `rst_ni` in the middle of a list returns the block to the R1 state at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Run the power-up list |
| recal_req_i | input | 1 | Request the recalibration list |
| wr_done_i | input | 1 | Downstream writer has taken the current word |
| word_o | output | 32 | Register word to write, 0 when not valid |
| word_valid_o | output | 1 | `word_o` holds a word waiting for the writer |
| busy_o | output | 1 | A list is running, including its waits |
| init_done_o | output | 1 | Power-up list has completed |

## Verification
The bench answers handshakes with random latency. It logs every word taken and counts the low-valid cycles after each one, so three kinds of fault show up:
- A design that advanced on its own timing rather than on the handshake would skip or repeat words.
- A design that placed a wait on the wrong step would produce a gap on that step.
- A design that miscounted the wait by one cycle would produce a gap of the wrong length.

Two requests are pulsed mid-run. A start during the list checks that a restart is ignored. A recalibration request during the list checks that it is held until the end rather than dropped or started early. A recalibration request before the first start checks that it is rejected. A reset in the middle of a list checks that the block returns to idle with `init_done_o` cleared.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

  typedef enum logic [1:0] {WT_NONE, WT_SHORT, WT_MID, WT_LONG} wait_e;
  typedef enum logic {LST_INIT, LST_RECAL} list_e;

  localparam int INIT_LEN  = 21;
  localparam int RECAL_LEN = 4;
  localparam int IDX_W     = $clog2(INIT_LEN);

  // settling times in microseconds
  localparam int US_SHORT = 10;
  localparam int US_MID   = 400;
  localparam int US_LONG  = 800;

  function automatic logic [31:0] init_word(logic [IDX_W-1:0] i);
    case (i)
      5'd0:    return 32'h0200_0007;
      5'd1:    return 32'h0000_002B;
      5'd2:    return 32'h0000_000B;
      5'd3:    return 32'h1D32_A64A;
      5'd4:    return 32'h2A20_B929;
      5'd5:    return 32'h4000_3E88;
      5'd6:    return 32'h809F_E520;
      5'd7:    return 32'h011F_4827;
      5'd8:    return 32'h0000_0006;
      5'd9:    return 32'h01E2_8005;
      5'd10:   return 32'h0020_0004;
      5'd11:   return 32'h0189_0803;
      5'd12:   return 32'h0002_0642;
      5'd13:   return 32'hFFF7_FFE1;
      5'd14:   return 32'h809F_E720;
      5'd15:   return 32'h809F_E560;
      5'd16:   return 32'h809F_ED60;
      5'd17:   return 32'h809F_E5A0;
      5'd18:   return 32'h809F_F5A0;
      5'd19:   return 32'h2800_B929;
      default: return 32'h809F_25A0;
    endcase
  endfunction

  function automatic wait_e init_wait(logic [IDX_W-1:0] i);
    case (i)
      5'd6:         return WT_SHORT;
      5'd14:        return WT_LONG;
      5'd16, 5'd18: return WT_MID;
      default:      return WT_NONE;
    endcase
  endfunction

  function automatic logic [31:0] recal_word(logic [IDX_W-1:0] i);
    case (i)
      5'd0:    return 32'h809F_E520;
      5'd1:    return 32'h2A20_B929;
      5'd2:    return 32'hFFF7_FFE1;
      default: return 32'h809F_E720;
    endcase
  endfunction

  function automatic wait_e recal_wait(logic [IDX_W-1:0] i);
    return (i == 5'd3) ? WT_LONG : WT_NONE;
  endfunction

endpackage

// File: rtl/cfg_seq_rom.sv
module cfg_seq_rom
  import cfg_seq_pkg::*;
(
  input  list_e            list_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [31:0]      word_o,
  output wait_e            wait_o,
  output logic             last_o
);

  always_comb begin
    if (list_i == LST_INIT) begin
      word_o = init_word(idx_i);
      wait_o = init_wait(idx_i);
      last_o = (idx_i == IDX_W'(INIT_LEN - 1));
    end else begin
      word_o = recal_word(idx_i);
      wait_o = recal_wait(idx_i);
      last_o = (idx_i == IDX_W'(RECAL_LEN - 1));
    end
  end

endmodule

// File: rtl/cfg_seq_timer.sv
module cfg_seq_timer
  import cfg_seq_pkg::*;
#(
  parameter int CYC_PER_US = 50
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  load_i,
  input  wait_e wait_i,
  output logic  zero_o
);

  localparam int D_SHORT = US_SHORT * CYC_PER_US;
  localparam int D_MID   = US_MID * CYC_PER_US;
  localparam int D_LONG  = US_LONG * CYC_PER_US;
  localparam int CNT_W   = $clog2(D_LONG);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_val;

  // counter covers D cycles: loaded with D-1, the cycle at zero is the last
  always_comb begin
    case (wait_i)
      WT_SHORT: load_val = CNT_W'(D_SHORT - 1);
      WT_MID:   load_val = CNT_W'(D_MID - 1);
      WT_LONG:  load_val = CNT_W'(D_LONG - 1);
      default:  load_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // R5
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(D_LONG - 1));

  // R5
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

endmodule

// File: rtl/cfg_seq_ctrl.sv
module cfg_seq_ctrl
  import cfg_seq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             recal_req_i,
  input  logic             wr_done_i,
  input  wait_e            wait_i,
  input  logic             last_i,
  input  logic             tmr_zero_i,
  output logic             tmr_load_o,
  output list_e            list_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             send_o,
  output logic             busy_o,
  output logic             init_done_o
);

  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_WAIT} state_e;

  state_e           state_q;
  list_e            list_q;
  logic [IDX_W-1:0] idx_q;
  logic             done_q;
  logic             pend_q;

  assign tmr_load_o = (state_q == ST_SEND) && wr_done_i && (wait_i != WT_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      list_q  <= LST_INIT;
      idx_q   <= '0;
      done_q  <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      if (recal_req_i && state_q != ST_IDLE) pend_q <= 1'b1;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_SEND;
            list_q  <= LST_INIT;
            idx_q   <= '0;
            done_q  <= 1'b0;
          end else if (done_q && (pend_q || recal_req_i)) begin
            state_q <= ST_SEND;
            list_q  <= LST_RECAL;
            idx_q   <= '0;
            pend_q  <= 1'b0;
          end
        end
        ST_SEND: begin
          if (wr_done_i) begin
            if (wait_i != WT_NONE) begin
              state_q <= ST_WAIT;
            end else if (last_i) begin
              state_q <= ST_IDLE;
              if (list_q == LST_INIT) done_q <= 1'b1;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        ST_WAIT: begin
          if (tmr_zero_i) begin
            if (last_i) begin
              state_q <= ST_IDLE;
              if (list_q == LST_INIT) done_q <= 1'b1;
            end else begin
              state_q <= ST_SEND;
              idx_q   <= idx_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign list_o      = list_q;
  assign idx_o       = idx_q;
  assign send_o      = (state_q == ST_SEND);
  assign busy_o      = (state_q != ST_IDLE);
  assign init_done_o = done_q;

  // R7
  recal_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && list_q == LST_RECAL) |-> done_q);

  // R10
  restart_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $stable(list_q)) |=> (idx_q == $past(idx_q) || idx_q == $past(idx_q) + 1'b1));

endmodule

// File: rtl/cfg_seq_top.sv
module cfg_seq_top
  import cfg_seq_pkg::*;
#(
  parameter int CYC_PER_US = 50
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        recal_req_i,
  input  logic        wr_done_i,
  output logic [31:0] word_o,
  output logic        word_valid_o,
  output logic        busy_o,
  output logic        init_done_o
);

  list_e            list;
  logic [IDX_W-1:0] idx;
  logic [31:0]      rom_word;
  wait_e            rom_wait;
  logic             rom_last;
  logic             tmr_load;
  logic             tmr_zero;
  logic             send;

  cfg_seq_rom u_rom (
    .list_i (list),
    .idx_i  (idx),
    .word_o (rom_word),
    .wait_o (rom_wait),
    .last_o (rom_last)
  );

  cfg_seq_timer #(.CYC_PER_US(CYC_PER_US)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .wait_i (rom_wait),
    .zero_o (tmr_zero)
  );

  cfg_seq_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .recal_req_i (recal_req_i),
    .wr_done_i   (wr_done_i),
    .wait_i      (rom_wait),
    .last_i      (rom_last),
    .tmr_zero_i  (tmr_zero),
    .tmr_load_o  (tmr_load),
    .list_o      (list),
    .idx_o       (idx),
    .send_o      (send),
    .busy_o      (busy_o),
    .init_done_o (init_done_o)
  );

  assign word_valid_o = send;
  assign word_o       = send ? rom_word : 32'h0;

  // R3
  word_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_valid_o && !wr_done_i) |=> (word_valid_o && $stable(word_o)));

  // R11
  addr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |-> (word_o[4:0] <= 5'd11));

  // R6
  done_on_hs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(init_done_o) |-> $past(word_valid_o && wr_done_i));

  // R10
  done_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(init_done_o) |-> $past(start_i && !busy_o));

endmodule

// File: tb/tb_cfg_seq_top.sv
module tb_cfg_seq_top;

  localparam int CPU = 4;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic        start_i, recal_req_i, wr_done_i;
  logic [31:0] word_o;
  logic        word_valid_o, busy_o, init_done_o;

  int total = 0;
  int bad   = 0;

  logic [31:0] log_w [0:63];
  int          log_g [0:63];
  int          log_n = 0;
  int          gap_cnt = 0;
  bit          gap_open = 0;
  int          lat = 0;

  always #10 clk = ~clk;

  cfg_seq_top #(.CYC_PER_US(CPU)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .recal_req_i(recal_req_i),
    .wr_done_i(wr_done_i), .word_o(word_o), .word_valid_o(word_valid_o),
    .busy_o(busy_o), .init_done_o(init_done_o)
  );

  function automatic logic [31:0] exp_word(bit recal, int i);
    if (recal) begin
      case (i)
        0: return 32'h809FE520; 1: return 32'h2A20B929;
        2: return 32'hFFF7FFE1; default: return 32'h809FE720;
      endcase
    end
    case (i)
      0: return 32'h02000007;  1: return 32'h0000002B;  2: return 32'h0000000B;
      3: return 32'h1D32A64A;  4: return 32'h2A20B929;  5: return 32'h40003E88;
      6: return 32'h809FE520;  7: return 32'h011F4827;  8: return 32'h00000006;
      9: return 32'h01E28005;  10: return 32'h00200004; 11: return 32'h01890803;
      12: return 32'h00020642; 13: return 32'hFFF7FFE1; 14: return 32'h809FE720;
      15: return 32'h809FE560; 16: return 32'h809FED60; 17: return 32'h809FE5A0;
      18: return 32'h809FF5A0; 19: return 32'h2800B929; default: return 32'h809F25A0;
    endcase
  endfunction

  function automatic int exp_gap(bit recal, int i);
    if (recal) return (i == 3) ? 800 * CPU : 0;
    case (i)
      6:       return 10 * CPU;
      14:      return 800 * CPU;
      16, 18:  return 400 * CPU;
      default: return 0;
    endcase
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  // writer model: random handshake latency, logs words and post-word gaps
  initial begin
    wr_done_i = 1'b0;
    forever begin
      @(negedge clk);
      if (!rst_ni) begin
        wr_done_i = 1'b0;
        gap_open  = 0;
      end else begin
        if (gap_open && busy_o && !word_valid_o) gap_cnt++;
        if (gap_open && !busy_o) begin
          log_g[log_n-1] = gap_cnt;
          gap_open = 0;
        end
        if (wr_done_i) wr_done_i = 1'b0;
        else if (word_valid_o) begin
          if (lat == 0) begin
            wr_done_i = 1'b1;
            if (log_n > 0 && gap_open) log_g[log_n-1] = gap_cnt;
            if (log_n < 64) begin
              log_w[log_n] = word_o;
              log_g[log_n] = -1;
              log_n++;
            end
            gap_cnt  = 0;
            gap_open = 1;
            lat = $urandom % 4;
          end else lat--;
        end
      end
    end
  end

  task automatic clear_log();
    log_n = 0; gap_cnt = 0; gap_open = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic pulse_recal();
    @(negedge clk); recal_req_i = 1'b1;
    @(negedge clk); recal_req_i = 1'b0;
  endtask

  task automatic wait_idle(int maxc);
    int k = 0;
    while (busy_o && k < maxc) begin @(negedge clk); k++; end
  endtask

  task automatic check_list(bit recal, int off, string tag);
    int n = recal ? 4 : 21;
    for (int i = 0; i < n; i++) begin
      chk(log_w[off+i] == exp_word(recal, i), tag, log_w[off+i], exp_word(recal, i));
      chk(log_w[off+i][4:0] <= 5'd11, "R11 addr", log_w[off+i][4:0], 11);
      chk(log_g[off+i] == exp_gap(recal, i), recal ? "R7/R5 gap" : "R5/R4 gap",
          log_g[off+i], exp_gap(recal, i));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int k;
    void'($urandom(32'h5EED_0042));
    rst_ni = 1'b0; start_i = 1'b0; recal_req_i = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1
    chk(!busy_o && !word_valid_o && !init_done_o && word_o == 0, "R1 reset",
        {busy_o, word_valid_o, init_done_o}, 0);
    rst_ni = 1'b1;

    // R8: recal before init dropped
    pulse_recal();
    repeat (5) @(negedge clk);
    chk(!busy_o && log_n == 0, "R8 recal before init", log_n, 0);

    // phase A: init with stray start (R10) and mid-run recal (R9)
    clear_log();
    pulse_start();
    chk(busy_o == 1'b1, "R2 busy after start", busy_o, 1);
    repeat (40) @(negedge clk);
    pulse_start();
    repeat (60) @(negedge clk);
    pulse_recal();
    k = 0;
    while (!init_done_o && k < 20000) begin @(negedge clk); k++; end
    chk(init_done_o && !busy_o, "R6 done with idle", {init_done_o, busy_o}, 2);
    @(negedge clk);
    chk(busy_o == 1'b1, "R9 latched recal launches", busy_o, 1);
    wait_idle(20000);
    @(negedge clk);
    chk(log_n == 25, "R3/R10 word count", log_n, 25);
    check_list(0, 0, "R2 init order");
    check_list(1, 21, "R9 recal order");
    chk(init_done_o == 1'b1, "R7 done kept", init_done_o, 1);

    // phase B: recal from idle, busy through final wait
    clear_log();
    pulse_recal();
    k = 0;
    while (log_n < 4 && k < 1000) begin @(negedge clk); k++; end
    repeat (100 * CPU) @(negedge clk);
    chk(busy_o && !word_valid_o && init_done_o, "R7 busy during wait",
        {busy_o, word_valid_o, init_done_o}, 5);
    wait_idle(20000);
    @(negedge clk);
    chk(log_n == 4, "R7 recal count", log_n, 4);
    check_list(1, 0, "R7 recal order");

    // phase C: restart clears done, then reset mid-run
    clear_log();
    pulse_start();
    chk(!init_done_o && busy_o, "R10 restart clears done", {init_done_o, busy_o}, 1);
    repeat (300 + ($urandom % 200)) @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    chk(!busy_o && !word_valid_o && !init_done_o && word_o == 0, "R12 mid-run reset",
        {busy_o, word_valid_o, init_done_o}, 0);
    rst_ni = 1'b1;
    pulse_recal();
    repeat (3) @(negedge clk);
    chk(!busy_o, "R8 recal after reset dropped", busy_o, 0);

    // phase D: clean init, random latencies
    clear_log();
    pulse_start();
    wait_idle(20000);
    @(negedge clk);
    chk(log_n == 21 && init_done_o, "R3/R6 clean init", log_n, 21);
    check_list(0, 0, "R2 init order rerun");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule